// File: doc/BRIEF.md
# Run-Time Configurable Binary Extension Field Multiplier

This block multiplies two elements of a binary extension field GF(2^m). The field size m and the reduction polynomial are given with each request rather than fixed when the chip is built. One instance can therefore serve any field from GF(2) up to GF(2^MAX_M). A request carries two field elements, the full modulus polynomial (its leading x^m term included), a 5-bit degree and a 2-bit operation code.

Multiplication is bit-serial. The unit walks the second multiplicand from bit m-1 down to bit 0, one bit per clock. In each step it doubles the running value, folds in the modulus when the doubled value reaches x^m, and adds the first multiplicand when the current bit is set. A carry-less add, which is a plain XOR over the same field, finishes in a single cycle.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle. The unit holds one transaction at a time, so it takes no new request while it is computing or while a result waits for the consumer. A result stays on `out_data` with `out_valid` high until a clock edge where `out_ready` is high. The consumer may hold `out_ready` low for any number of cycles.

Top module: `gf_mul_unit`

## Requirements
- R1: `in_ready` is high exactly when the unit holds no transaction. A request is taken only on an edge with `in_valid` and `in_ready` both high, and `in_ready` is low in the cycle after that edge.
- R2: With op code 00 (multiply) and effective degree d >= 1, the result is the product a*b reduced modulo the polynomial. Only bits d-1..0 of `in_poly` are used, the x^d term is implied, and the result is below 2^d.
- R3: A multiply with effective degree d >= 1 raises `out_valid` d clock cycles after the accepting edge. Every other request raises `out_valid` right after the accepting edge.
- R4: With op code 01 (add), the result is (a XOR b) restricted to bits d-1..0.
- R5: Operand bits of `in_a` and `in_b` at positions d and above have no effect on any result.
- R6: A degree above MAX_M is treated as MAX_M. Degree 0 returns 0 for both multiply and add.
- R7: Op codes 10 and 11 return 0 with single-cycle latency.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R9: In GF(2^3) with modulus 0b1011, 0b111 times 0b101 gives 0b110. In GF(2^8) with modulus 0x11B, 0x80 times 0x83 gives 0x01.
- R10: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to take a request |
| in_op | input | 2 | 00 multiply, 01 add, 10/11 reserved |
| in_a | input | MAX_M | First field element |
| in_b | input | MAX_M | Second field element |
| in_poly | input | MAX_M+1 | Modulus polynomial including its x^m term |
| in_deg | input | 5 | Field degree m |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | MAX_M | Result field element |

## Verification
The assertions check three things on every cycle. They check that the input and output handshakes never overlap and that a taken request drops `in_ready`. They check that a stalled result holds still and that the bit counter of a running multiply steps down by one per cycle. They also check that a presented result never has bits at or above the latched degree.

The correctness of the reduced product, the exact latency for each degree, and the effect of degree clamping and operand masking need the bench's reference model. The bench runs the worked field examples, random operands across several field sizes, and random back-pressure.

// File: rtl/gf_mul_pkg.sv
package gf_mul_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_ADD  = 2'b01,
    OP_RSV2 = 2'b10,
    OP_RSV3 = 2'b11
  } gf_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_HOLD = 2'b10
  } gf_state_e;
endpackage

// File: rtl/gf_deg_decode.sv
module gf_deg_decode #(
  parameter int MAX_M = 8,
  parameter int DEG_W = 5,
  parameter int CNT_W = $clog2(MAX_M + 1)
) (
  input  logic [DEG_W-1:0] deg_i,
  output logic [CNT_W-1:0] eff_o,
  output logic [MAX_M-1:0] mask_o
);
  always_comb begin
    if (32'(deg_i) > MAX_M) eff_o = CNT_W'(MAX_M);
    else                    eff_o = CNT_W'(deg_i);
  end

  for (genvar g = 0; g < MAX_M; g++) begin : g_mask
    assign mask_o[g] = (32'(eff_o) > g);
  end
endmodule

// File: rtl/gf_shift_step.sv
module gf_shift_step #(
  parameter int W     = 8,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     acc_i,
  input  logic [W-1:0]     addend_i,
  input  logic [W-1:0]     fold_i,
  input  logic [W-1:0]     mask_i,
  input  logic [CNT_W-1:0] deg_i,
  input  logic             bit_i,
  output logic [W-1:0]     acc_o
);
  logic [W:0]   doubled;
  logic [W:0]   probe;
  logic [W-1:0] reduced;

  always_comb begin
    doubled = {acc_i, 1'b0};
    probe   = doubled >> deg_i;
    reduced = doubled[W-1:0] & mask_i;
    if (probe[0]) reduced = reduced ^ fold_i;
    acc_o = bit_i ? (reduced ^ addend_i) : reduced;
  end
endmodule

// File: rtl/gf_mul_unit.sv
module gf_mul_unit #(
  parameter int MAX_M = 8,
  parameter int DEG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [MAX_M-1:0] in_a,
  input  logic [MAX_M-1:0] in_b,
  input  logic [MAX_M:0]   in_poly,
  input  logic [DEG_W-1:0] in_deg,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MAX_M-1:0] out_data
);
  import gf_mul_pkg::*;

  localparam int CNT_W = $clog2(MAX_M + 1);

  gf_state_e        state_q;
  logic [MAX_M-1:0] a_q, b_q, fold_q, mask_q, acc_q;
  logic [CNT_W-1:0] deg_q, cnt_q;

  logic [CNT_W-1:0] eff_deg;
  logic [MAX_M-1:0] eff_mask;
  logic [MAX_M-1:0] a_in_m, b_in_m;
  logic [MAX_M-1:0] step_acc;
  logic [CNT_W-1:0] bit_idx;
  logic [MAX_M-1:0] b_shifted;
  logic             take;
  gf_op_e           op_in;

  gf_deg_decode #(.MAX_M(MAX_M), .DEG_W(DEG_W), .CNT_W(CNT_W)) u_dec (
    .deg_i  (in_deg),
    .eff_o  (eff_deg),
    .mask_o (eff_mask)
  );

  assign a_in_m    = in_a & eff_mask;
  assign b_in_m    = in_b & eff_mask;
  assign op_in     = gf_op_e'(in_op);
  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign out_data  = acc_q;
  assign take      = in_valid && in_ready;

  assign bit_idx   = cnt_q - 1'b1;
  assign b_shifted = b_q >> bit_idx;

  gf_shift_step #(.W(MAX_M), .CNT_W(CNT_W)) u_step (
    .acc_i    (acc_q),
    .addend_i (a_q),
    .fold_i   (fold_q),
    .mask_i   (mask_q),
    .deg_i    (deg_q),
    .bit_i    (b_shifted[0]),
    .acc_o    (step_acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      fold_q  <= '0;
      mask_q  <= '0;
      acc_q   <= '0;
      deg_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            a_q    <= a_in_m;
            b_q    <= b_in_m;
            fold_q <= in_poly[MAX_M-1:0] & eff_mask;
            mask_q <= eff_mask;
            deg_q  <= eff_deg;
            cnt_q  <= eff_deg;
            if (op_in == OP_MUL && eff_deg != '0) begin
              acc_q   <= '0;
              state_q <= ST_RUN;
            end else begin
              acc_q   <= (op_in == OP_ADD) ? (a_in_m ^ b_in_m) : '0;
              state_q <= ST_HOLD;
            end
          end
        end
        ST_RUN: begin
          acc_q <= step_acc;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R1
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3
  run_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q > CNT_W'(1)) |=>
      (state_q == ST_RUN && cnt_q == $past(cnt_q) - 1'b1));

  // R2
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & ~mask_q) == '0));
endmodule

// File: tb/gf_mul_unit_tb.sv
module gf_mul_unit_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_op = 2'b00;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [W:0]   in_poly = '0;
  logic [4:0]   in_deg = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    bp_mode = 1'b0;
  bit    running = 1'b0;
  string cur_tag = "R2";

  int    m_state = 0;
  int    m_wait = 0;
  int    m_res = 0;
  string m_tag = "R2";
  bit    prev_stall = 1'b0;
  int    prev_data = 0;

  always #4 clk = ~clk;

  gf_mul_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_poly(in_poly),
    .in_deg(in_deg), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic int gf_ref(int op, int a, int b, int p, int d);
    int e = (d > W) ? W : d;
    int m = (1 << e) - 1;
    int r = 0;
    a = a & m;
    b = b & m;
    if (op == 1) return a ^ b;
    if (op != 0 || e == 0) return 0;
    for (int i = 0; i < e; i++) begin
      if (((b >> i) & 1) != 0) r = r ^ a;
      a = a << 1;
      if (((a >> e) & 1) != 0) a = (a ^ p) & m;
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, advanced on every edge from the bench's own inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0;
    end else begin
      case (m_state)
        0: if (in_valid) begin
             int e;
             e = (int'(in_deg) > W) ? W : int'(in_deg);
             m_res = gf_ref(int'(in_op), int'(in_a), int'(in_b), int'(in_poly), int'(in_deg));
             m_tag = cur_tag;
             if (in_op == 2'b00 && e > 0) begin
               m_state = 1;
               m_wait = e;
             end else m_state = 2;
           end
        1: begin
             m_wait--;
             if (m_wait == 0) m_state = 2;
           end
        default: if (out_ready) m_state = 0;
      endcase
    end
  end

  // compare after each edge has settled
  always @(posedge clk) begin
    #2;
    cycles++;
    if (running) begin
      check("R1", int'(in_ready), (m_state == 0) ? 1 : 0);
      check("R3", int'(out_valid), (m_state == 2) ? 1 : 0);
      if (m_state == 2 && out_valid) check(m_tag, int'(out_data), m_res);
      if (prev_stall) check("R8", int'(out_data), prev_data);
      prev_stall = out_valid && !out_ready;
      prev_data = int'(out_data);
    end
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) out_ready <= bp_mode ? 1'($urandom % 2) : 1'b1;

  task automatic issue(input logic [1:0] op, input int a, input int b,
                       input int p, input int d, input string tag);
    @(negedge clk);
    in_op = op; in_a = W'(a); in_b = W'(b); in_poly = (W+1)'(p);
    in_deg = 5'(d); cur_tag = tag; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    check("R10", int'(in_ready), 1);
    check("R10", int'(out_valid), 0);
    check("R10", int'(out_data), 0);
    running = 1'b1;

    // R9 worked examples
    issue(2'b00, 7, 5, 'b1011, 3, "R9");
    issue(2'b00, 'h80, 'h83, 'h11B, 8, "R9");

    // R2 several fields, random operands
    for (int i = 0; i < 20; i++) issue(2'b00, $urandom % 256, $urandom % 256, 'h11B, 8, "R2");
    for (int i = 0; i < 10; i++) issue(2'b00, $urandom % 16, $urandom % 16, 'h13, 4, "R2");
    for (int i = 0; i < 6; i++)  issue(2'b00, $urandom % 32, $urandom % 32, 'h25, 5, "R2");
    issue(2'b00, 1, 1, 'h3, 1, "R2");

    // R5 high operand bits ignored
    issue(2'b00, 'hF3, 'hA7, 'h13, 4, "R5");
    issue(2'b01, 'hFF, 'h5A, 'h13, 4, "R5");
    issue(2'b00, 'hE6, 'hF9, 'h0B, 3, "R5");

    // R4 add
    for (int i = 0; i < 6; i++) issue(2'b01, $urandom % 256, $urandom % 256, 'h11B, 8, "R4");
    issue(2'b01, 'h0C, 'h0A, 'h13, 4, "R4");

    // R6 degree clamp and degree zero
    issue(2'b00, 'hC5, 'h3B, 'h11B, 12, "R6");
    issue(2'b00, 'h57, 'h83, 'h11B, 31, "R6");
    issue(2'b00, 'h55, 'hAA, 'h11B, 0, "R6");
    issue(2'b01, 'h55, 'hAA, 'h11B, 0, "R6");

    // R7 reserved codes
    issue(2'b10, 'h12, 'h34, 'h11B, 8, "R7");
    issue(2'b11, 'hFF, 'hFF, 'h11B, 8, "R7");

    // R8 random back-pressure with mixed traffic
    bp_mode = 1'b1;
    for (int i = 0; i < 25; i++)
      issue(2'($urandom % 4), $urandom % 256, $urandom % 256, 'h11B, 1 + ($urandom % 8), "R2");
    bp_mode = 1'b0;

    while (m_state != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule